// File: doc/BRIEF.md
# Windowed Survivor Traceback Unit

This unit is the back end of a soft-decision trellis decoder. Each accepted step it takes one word of survivor decisions, with one bit per trellis state, plus the index of the state the path-metric core currently favours. It writes the word into storage and turns the stored decisions back into decoded data bits. Under a continuous input it emits one bit for every step it accepts, and the latency is the same whatever the data.

Two identical synchronous memories receive every write. One feeds a merge engine. At the end of each window of `TB_DEPTH` steps, this engine starts at the favoured state and walks one window backwards until the path has settled. The other memory feeds a decode engine. It continues from where the merge engine stopped and walks the window before that one, producing bits newest first. A small two-bank reversal buffer puts the bits back into time order. Storage is split into four rolling regions. In any window, one region is being written, one is being merged, one is waiting and one is being decoded.

All control comes from one timeline: a position counter inside the window, a 2-bit region index, and a startup count that stops at four windows. There is no state machine. The input side has only a valid signal and no ready signal: every cycle with `in_valid` high is consumed. Cycles with `in_valid` low freeze the whole timeline. The output is also valid-only and has no back-pressure. `out_valid` is a one-cycle pulse in the cycle after an accepted step, and only once the pipeline is full. Packets can follow each other with no reset between them.

Top module: `surv_traceback`

## Requirements
- R1: After reset, `out_valid` and `out_bit` are 0, and `out_valid` stays 0 until 4·TB_DEPTH steps have been accepted.
- R2: Bit n of the output stream, counting from the first step after reset, is the most significant bit of the traced state for accepted step n. Bit 5 of the 6-bit state holds the newest input.
- R3: A traceback step reads decision bit `in_dec[s]` for the current state s and moves to the earlier state ((s << 1) | bit) & 63.
- R4: With `in_valid` held high, the bit for the step presented in cycle c appears in cycle c + 4·TB_DEPTH + 1.
- R5: `in_best` is used only on steps whose window position (accepted-step index modulo TB_DEPTH) is TB_DEPTH−1. Its value on any other step has no effect on the output.
- R6: The merge engine takes its first decision from the word accepted in that same step. The write-first bypass forwards that word instead of the older memory contents at the same address.
- R7: A cycle with `in_valid` low advances nothing. `out_valid` is 0 in the cycle after it, and the output bit sequence is the same as it would be with no gap.
- R8: Operation continues indefinitely without a reset. Each accepted step after the startup period produces exactly one output bit, in time order.
- R9: `out_valid` is 1 exactly in the cycle after each accepted step that has at least 4·TB_DEPTH accepted steps before it.
- R10: If every bit of each decision word holds the same value, the output matches the encoded path even when `in_best` is arbitrary on every step, because the merge walk converges within TB_DEPTH steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A step is presented this cycle and is accepted |
| in_dec | input | 64 | Survivor decision bit for each of the 64 states |
| in_best | input | 6 | Index of the state currently favoured by the path-metric core |
| out_valid | output | 1 | `out_bit` carries a decoded bit this cycle |
| out_bit | output | 1 | Decoded data bit, in time order |

## Verification
The hardest case to reach from the ports is the bypass. It only matters on the last step of a window, when the merge engine reads the very address being written in that cycle. It shows up only if the stale word differs from the new one at the start state. Random decision words cover this: every bit except the true predecessor bit is random, so a stale read sends the traceback down a wrong path. Random valid gaps test that the timeline freezes. Words with every bit equal, combined with a nonsense favoured state, test that the merge engine converges. A reset in the middle of the run followed by a continuous stream tests re-arming and the fixed latency.

// File: rtl/trbk_pkg.sv
package trbk_pkg;
  localparam int unsigned REGIONS      = 4;
  localparam int unsigned REG_W        = $clog2(REGIONS);
  localparam int unsigned WARM_WINDOWS = REGIONS;
  typedef logic [REG_W-1:0] region_t;
endpackage

// File: rtl/survivor_mem.sv
module survivor_mem #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // read-first: a same-address read returns the word held before this write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trace_timeline.sv
module trace_timeline
  import trbk_pkg::*;
#(
  parameter int unsigned TB_DEPTH = 42,
  parameter int unsigned POS_W    = $clog2(TB_DEPTH),
  parameter int unsigned ADDR_W   = POS_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  output logic [POS_W-1:0]  pos,
  output logic              first,
  output logic              bank,
  output logic              warm,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] maddr,
  output logic [ADDR_W-1:0] daddr
);
  localparam int unsigned PH_W = $clog2(WARM_WINDOWS + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(TB_DEPTH - 1);
  localparam logic [PH_W-1:0]  WARM_CNT = PH_W'(WARM_WINDOWS);

  logic [POS_W-1:0] pos_q;
  region_t          reg_q;
  logic [PH_W-1:0]  phase_q;
  logic             wrap;
  region_t          mreg, dreg;
  logic [POS_W-1:0] rd_pos;

  assign wrap = (pos_q == LAST_POS);
  assign warm = (phase_q == WARM_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      reg_q   <= '0;
      phase_q <= '0;
    end else if (step_en) begin
      pos_q <= wrap ? '0 : pos_q + POS_W'(1);
      if (wrap) begin
        reg_q <= region_t'(reg_q + region_t'(1));
        if (!warm) phase_q <= phase_q + PH_W'(1);
      end
    end
  end

  // On the last step of a window, both engines start at the newest entry.
  // On every other step they walk one position further back.
  always_comb begin
    rd_pos = wrap ? LAST_POS : (LAST_POS - pos_q - POS_W'(1));
    mreg   = wrap ? reg_q : region_t'(reg_q - region_t'(1));
    dreg   = region_t'(mreg - region_t'(2));
  end

  assign pos   = pos_q;
  assign first = (pos_q == '0);
  assign bank  = reg_q[0];
  assign waddr = {reg_q, pos_q};
  assign maddr = {mreg, rd_pos};
  assign daddr = {dreg, rd_pos};

  AST_COLLIDE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (maddr == waddr) |-> (pos_q == LAST_POS)); // R6
  AST_WARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    warm |=> warm); // R8
endmodule

// File: rtl/trace_pair.sv
module trace_pair #(
  parameter int unsigned SB = 6,
  parameter int unsigned NS = 1 << SB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          first,
  input  logic [SB-1:0] best,
  input  logic [NS-1:0] merge_word,
  input  logic [NS-1:0] dec_word,
  output logic          dec_bit
);
  logic [SB-1:0] m_state_q, d_state_q;
  logic [SB-1:0] m_cur, d_cur, m_nxt, d_nxt;

  // merge engine: seeded by the favoured state at the start of each window
  // decode engine: seeded by the state where the merge walk ended
  always_comb begin
    m_cur   = first ? best : m_state_q;
    d_cur   = first ? m_state_q : d_state_q;
    m_nxt   = {m_cur[SB-2:0], merge_word[m_cur]};
    d_nxt   = {d_cur[SB-2:0], dec_word[d_cur]};
    dec_bit = d_cur[SB-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_state_q <= '0;
      d_state_q <= '0;
    end else if (step_en) begin
      m_state_q <= m_nxt;
      d_state_q <= d_nxt;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(m_state_q) && $stable(d_state_q))); // R7
endmodule

// File: rtl/order_lifo.sv
module order_lifo #(
  parameter int unsigned DEPTH = 42,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             wbank,
  input  logic [IDX_W-1:0] widx,
  input  logic             wbit,
  input  logic [IDX_W-1:0] ridx,
  output logic             out_bit
);
  logic [DEPTH-1:0] store_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q[0] <= '0;
      store_q[1] <= '0;
      out_bit    <= 1'b0;
    end else if (step_en) begin
      store_q[wbank][widx] <= wbit;
      out_bit              <= store_q[~wbank][ridx];
    end
  end
endmodule

// File: rtl/surv_traceback.sv
module surv_traceback
  import trbk_pkg::*;
#(
  parameter int unsigned STATE_BITS = 6,
  parameter int unsigned TB_DEPTH   = 42
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [(1<<STATE_BITS)-1:0] in_dec,
  input  logic [STATE_BITS-1:0]      in_best,
  output logic                       out_valid,
  output logic                       out_bit
);
  localparam int unsigned NSTATES = 1 << STATE_BITS;
  localparam int unsigned POS_W   = $clog2(TB_DEPTH);
  localparam int unsigned ADDR_W  = POS_W + REG_W;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(TB_DEPTH - 1);

  logic [POS_W-1:0]   pos;
  logic               first, bank, warm;
  logic [ADDR_W-1:0]  waddr, maddr, daddr;
  logic [ADDR_W-1:0]  rd_addr [2];
  logic [NSTATES-1:0] rd_word [2];
  logic               byp_hit_q;
  logic [NSTATES-1:0] byp_word_q;
  logic [STATE_BITS-1:0] best_q;
  logic [NSTATES-1:0] merge_word;
  logic               dec_bit;
  logic               out_valid_q;

  trace_timeline #(.TB_DEPTH(TB_DEPTH), .POS_W(POS_W), .ADDR_W(ADDR_W)) u_timeline (
    .clk(clk), .rst_n(rst_n), .step_en(in_valid),
    .pos(pos), .first(first), .bank(bank), .warm(warm),
    .waddr(waddr), .maddr(maddr), .daddr(daddr)
  );

  assign rd_addr[0] = maddr;
  assign rd_addr[1] = daddr;

  // copy 0 serves the merge engine, copy 1 the decode engine
  for (genvar g = 0; g < 2; g++) begin : g_copy
    survivor_mem #(.WORD_W(NSTATES), .ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .we(in_valid), .waddr(waddr), .wdata(in_dec),
      .re(in_valid), .raddr(rd_addr[g]), .rdata(rd_word[g])
    );
  end

  // one-deep write-first bypass for the merge read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_hit_q  <= 1'b0;
      byp_word_q <= '0;
      best_q     <= '0;
    end else if (in_valid) begin
      byp_hit_q  <= (maddr == waddr);
      byp_word_q <= in_dec;
      best_q     <= in_best;
    end
  end

  assign merge_word = byp_hit_q ? byp_word_q : rd_word[0];

  trace_pair #(.SB(STATE_BITS), .NS(NSTATES)) u_pair (
    .clk(clk), .rst_n(rst_n), .step_en(in_valid), .first(first),
    .best(best_q), .merge_word(merge_word), .dec_word(rd_word[1]),
    .dec_bit(dec_bit)
  );

  order_lifo #(.DEPTH(TB_DEPTH), .IDX_W(POS_W)) u_lifo (
    .clk(clk), .rst_n(rst_n), .step_en(in_valid), .wbank(bank),
    .widx(LAST_POS - pos), .wbit(dec_bit), .ridx(pos), .out_bit(out_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid_q <= 1'b0;
    else        out_valid_q <= in_valid && warm;
  end

  assign out_valid = out_valid_q;

  AST_BYP_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (maddr == waddr)) |=> (merge_word == $past(in_dec))); // R6
  AST_OUT_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R9
  AST_COLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !warm |=> !out_valid); // R1
endmodule

// File: tb/surv_traceback_tb_top.sv
module surv_traceback_tb_top;
  localparam int D   = 42;
  localparam int LAT = 4 * D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_dec = '0;
  logic [5:0]  in_best = '0;
  logic        out_valid, out_bit;

  surv_traceback dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec),
    .in_best(in_best), .out_valid(out_valid), .out_bit(out_bit)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit exp_q[$];
  int acc, nd, popped, first_in, first_out;
  bit pv, lat_check, done;
  logic [5:0] s_path = '0;
  string cur_tag = "R2";

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sample_outputs();
    bit exp_v, eb;
    exp_v = pv && (acc >= LAT);
    check(out_valid === exp_v, (acc < LAT) ? "R1" : "R9", "out_valid", out_valid, exp_v);
    if (out_valid && exp_v) begin
      if (first_out < 0) begin
        first_out = cyc;
        if (lat_check) check(first_out - first_in == LAT + 1, "R4", "latency", first_out - first_in, LAT + 1);
      end
      eb = exp_q.pop_front();
      popped++;
      check(out_bit === eb, cur_tag, "out_bit", out_bit, eb);
    end
    if (pv) acc++;
  endtask

  task automatic drive(bit v, logic [63:0] w, logic [5:0] b, bit u);
    @(negedge clk);
    sample_outputs();
    in_valid = v; in_dec = w; in_best = b;
    if (v) begin
      if (nd == 0) first_in = cyc;
      exp_q.push_back(u);
      nd++;
    end
    pv = v;
  endtask

  // mode 0: random words except the true predecessor bit; mode 1: replicated words
  task automatic gen_step(int mode, bit v);
    logic [5:0] prev, b;
    logic [63:0] w;
    bit u;
    if (!v) begin
      drive(1'b0, {$urandom, $urandom}, 6'($urandom), 1'b0);
    end else begin
      prev   = s_path;
      u      = 1'($urandom);
      s_path = {u, prev[5:1]};
      w      = {$urandom, $urandom};
      if (mode == 1) w = {64{prev[0]}};
      else           w[s_path] = prev[0];
      if (mode == 0 && (nd % D) == D - 1) b = s_path;
      else                                b = 6'($urandom);
      drive(1'b1, w, b, u);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; pv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
    acc = 0; nd = 0; popped = 0; first_in = -1; first_out = -1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_bit === 1'b0, "R1", "out_bit after reset", out_bit, 0);
  endtask

  task automatic end_phase();
    int want;
    drive(1'b0, '0, '0, 1'b0);
    @(negedge clk);
    sample_outputs();
    pv = 1'b0;
    want = (acc > LAT) ? acc - LAT : 0;
    check(popped == want, "R8", "bits emitted", popped, want);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // continuous, random words, best state random off the window end
    cur_tag = "R2 R3 R5 R6"; lat_check = 1'b1;
    for (int i = 0; i < 8 * D; i++) gen_step(0, 1'b1);
    end_phase();
    // random gaps, no reset in between
    cur_tag = "R7 R8"; lat_check = 1'b0;
    for (int i = 0; i < 10 * D; i++) gen_step(0, ($urandom % 10) < 7);
    end_phase();
    // replicated words with arbitrary best state
    cur_tag = "R10";
    for (int i = 0; i < 8 * D; i++) gen_step(1, ($urandom % 10) < 8);
    end_phase();
    // reset in the middle of the run, then re-arm and continuous operation
    do_reset();
    cur_tag = "R4 R8"; lat_check = 1'b1;
    for (int i = 0; i < 7 * D; i++) gen_step(0, 1'b1);
    end_phase();
    check(first_out >= 0, "R4", "output seen after re-arm", first_out >= 0, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule